// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupt Detection

This block is a general-purpose I/O peripheral with a configurable pin count (32 by default). Software uses a single-cycle register write port and a registered read port to control each pin. It can set the pin's drive direction, write the output value directly, or set and clear individual output bits without a read-modify-write sequence. Two pull-control words are kept in registers and driven straight to the pad ring. Two filter-control words are also present, but they only store and return what software writes. The block does no filtering.

Every pin input passes through a two-flop synchronizer. The synchronized value can be read back, and it also feeds a per-pin interrupt detector. Three configuration bits per pin select the trigger:
- a sensitivity bit chooses level or edge;
- an inversion bit chooses high/rising or low/falling;
- an any-edge bit, in edge mode, makes the pin fire on every transition.

Edge events are latched until software writes ones to the acknowledge word. Level status follows the qualified live level. A per-pin hide word keeps chosen pins off the single interrupt output. Hidden pins still record their status.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, every output of the block is zero. This covers `pin_out`, `pin_oe`, `pull_en`, `pull_up`, `irq` and `reg_rdata`.
- R2: A write to word offset 0x00 loads the output-value word, which appears on `pin_out` one cycle later. A write to offset 0x08 loads the direction word onto `pin_oe`. A direction bit of 1 makes that pin an output.
- R3: A write to offset 0x10 sets every output bit whose written bit is 1. A write to offset 0x14 clears every output bit whose written bit is 1. Written zeros leave those bits unchanged.
- R4: `reg_rdata` is registered. It shows, one cycle later, the register addressed by `reg_addr`. Offset 0x04 returns the pin levels after the two-flop synchronizer.
- R5: With the sensitivity bit (offset 0x34) at 1, the pin is level-sensitive. Its status bit (read at 0x24) follows the synchronized level XOR the inversion bit (offset 0x3C), so inversion 0 means active-high. Writes to the acknowledge word do not hold it low.
- R6: With the sensitivity bit at 0, the status bit is set by a rising edge when the inversion bit is 0, or by a falling edge when it is 1. An edge is a change between two successive synchronized samples. The bit then stays set.
- R7: In edge mode, a 1 in the any-edge word (offset 0x38) sets the status bit on every transition of that pin, whatever the inversion bit says.
- R8: Writing 1s to offset 0x30 clears the latched edge status of those pins. Writing all ones clears every pin. If an edge event and a clear for the same pin fall in the same cycle, the status bit ends up set.
- R9: A pin whose enable bit (offset 0x20) is 0 has its status bit held at 0.
- R10: `irq` is the registered OR of all status bits whose hide bit (offset 0x2C) is 0. A hidden pin still updates its status bit.
- R11: Offsets 0x18 and 0x1C drive `pull_en` and `pull_up`. Offsets 0x40 and 0x44 read back what was written. Write-only and unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (8) | Register byte offset |
| reg_wdata | input | NUM_PINS (32) | Write data |
| reg_rdata | output | NUM_PINS (32) | Registered read data |
| pin_in | input | NUM_PINS (32) | Asynchronous pin levels |
| pin_out | output | NUM_PINS (32) | Output values to pads |
| pin_oe | output | NUM_PINS (32) | Output enables (1 = drive) |
| pull_en | output | NUM_PINS (32) | Pull enable per pad |
| pull_up | output | NUM_PINS (32) | Pull direction per pad |
| irq | output | 1 | Combined interrupt request |

## Verification
Two functions can collide on one status bit in the same cycle: a latched edge event and a software acknowledge of that pin. The bench provokes this by changing the pins, waiting exactly the synchronizer depth, and then issuing the acknowledge write. The write lands on the cycle in which the edge is detected. A behavioural model gives priority to the event. It is compared with the status readback and the `irq` pin on every clock, and one extra check confirms that the bit survived the acknowledge.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  // Word offsets of the register window
  localparam int unsigned OFS_DOUT     = 'h00;
  localparam int unsigned OFS_SENSE    = 'h04;
  localparam int unsigned OFS_OE       = 'h08;
  localparam int unsigned OFS_SET      = 'h10;
  localparam int unsigned OFS_CLR      = 'h14;
  localparam int unsigned OFS_PULL_ON  = 'h18;
  localparam int unsigned OFS_PULL_UP  = 'h1C;
  localparam int unsigned OFS_ARM      = 'h20;
  localparam int unsigned OFS_PEND     = 'h24;
  localparam int unsigned OFS_HIDE     = 'h2C;
  localparam int unsigned OFS_ACK      = 'h30;
  localparam int unsigned OFS_LVL      = 'h34;
  localparam int unsigned OFS_ANY      = 'h38;
  localparam int unsigned OFS_INV      = 'h3C;
  localparam int unsigned OFS_FILT_ON  = 'h40;
  localparam int unsigned OFS_FILT_DIV = 'h44;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][W-1:0] chain;

  // Shift register: stage 0 samples the pad, the last stage is the safe copy
  always_ff @(posedge clk) begin
    if (rst) begin
      chain  <= '0;
      q_prev <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      q_prev <= chain[LAST];
    end
  end

  assign q = chain[LAST];

  // The previous-sample copy must lag the synchronized value by one cycle
  p_prev_lags_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (q_prev == $past(q)));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  input  logic [W-1:0]  sense,
  input  logic [W-1:0]  pend,
  output logic [W-1:0]  drive,
  output logic [W-1:0]  oe,
  output logic [W-1:0]  pull_on,
  output logic [W-1:0]  pull_up,
  output logic [W-1:0]  irq_arm,
  output logic [W-1:0]  irq_hide,
  output logic [W-1:0]  irq_lvl,
  output logic [W-1:0]  irq_any,
  output logic [W-1:0]  irq_inv,
  output logic [W-1:0]  ack
);
  logic [W-1:0] filt_on;
  logic [W-1:0] filt_div;
  logic [W-1:0] rd_mux;

  // Write-one-to-clear strobe, valid only in the write cycle
  assign ack = (wr_en && addr == AW'(OFS_ACK)) ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      drive    <= '0;
      oe       <= '0;
      pull_on  <= '0;
      pull_up  <= '0;
      irq_arm  <= '0;
      irq_hide <= '0;
      irq_lvl  <= '0;
      irq_any  <= '0;
      irq_inv  <= '0;
      filt_on  <= '0;
      filt_div <= '0;
    end else if (wr_en) begin
      case (addr)
        AW'(OFS_DOUT):     drive    <= wdata;
        AW'(OFS_SET):      drive    <= drive | wdata;
        AW'(OFS_CLR):      drive    <= drive & ~wdata;
        AW'(OFS_OE):       oe       <= wdata;
        AW'(OFS_PULL_ON):  pull_on  <= wdata;
        AW'(OFS_PULL_UP):  pull_up  <= wdata;
        AW'(OFS_ARM):      irq_arm  <= wdata;
        AW'(OFS_HIDE):     irq_hide <= wdata;
        AW'(OFS_LVL):      irq_lvl  <= wdata;
        AW'(OFS_ANY):      irq_any  <= wdata;
        AW'(OFS_INV):      irq_inv  <= wdata;
        AW'(OFS_FILT_ON):  filt_on  <= wdata;
        AW'(OFS_FILT_DIV): filt_div <= wdata;
        default: ;
      endcase
    end
  end

  // Read selection; strobe-only words return zero
  always_comb begin
    case (addr)
      AW'(OFS_DOUT):     rd_mux = drive;
      AW'(OFS_SENSE):    rd_mux = sense;
      AW'(OFS_OE):       rd_mux = oe;
      AW'(OFS_PULL_ON):  rd_mux = pull_on;
      AW'(OFS_PULL_UP):  rd_mux = pull_up;
      AW'(OFS_ARM):      rd_mux = irq_arm;
      AW'(OFS_PEND):     rd_mux = pend;
      AW'(OFS_HIDE):     rd_mux = irq_hide;
      AW'(OFS_LVL):      rd_mux = irq_lvl;
      AW'(OFS_ANY):      rd_mux = irq_any;
      AW'(OFS_INV):      rd_mux = irq_inv;
      AW'(OFS_FILT_ON):  rd_mux = filt_on;
      AW'(OFS_FILT_DIV): rd_mux = filt_div;
      default:           rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  p_set_raises_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(OFS_SET)) |=> ((drive & $past(wdata)) == $past(wdata)));
  p_set_keeps_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(OFS_SET)) |=> (((drive ^ $past(drive)) & ~$past(wdata)) == '0));
  p_clr_lowers_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(OFS_CLR)) |=> ((drive & $past(wdata)) == '0));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  input  logic [W-1:0] arm,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] inv,
  input  logic [W-1:0] any,
  input  logic [W-1:0] hide,
  input  logic [W-1:0] ack,
  output logic [W-1:0] pend,
  output logic         irq
);
  logic [W-1:0] hit;
  logic [W-1:0] pend_nxt;

  for (genvar i = 0; i < W; i++) begin : g_pin
    // Edge qualification: any-edge overrides the inversion bit
    assign hit[i] = any[i] ? (cur[i] ^ prev[i])
                  : (inv[i] ? (prev[i] & ~cur[i]) : (cur[i] & ~prev[i]));
    // Level status is live; edge status is sticky, event beats acknowledge
    assign pend_nxt[i] = !arm[i] ? 1'b0
                       : (lvl[i] ? (cur[i] ^ inv[i])
                                 : (hit[i] | (pend[i] & ~ack[i])));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      irq  <= 1'b0;
    end else begin
      pend <= pend_nxt;
      irq  <= |(pend & ~hide);
    end
  end

  p_unarmed_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (pend & ~$past(arm)) == '0);
  p_edge_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (~pend & $past(hit & ack & arm & ~lvl)) == '0);
  p_edge_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (~pend & $past(pend & ~ack & arm & ~lvl)) == '0);
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [NUM_PINS-1:0] reg_wdata,
  output logic [NUM_PINS-1:0] reg_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_PINS-1:0] pull_en,
  output logic [NUM_PINS-1:0] pull_up,
  output logic                irq
);
  localparam int SYNC_STAGES = 2;

  logic [NUM_PINS-1:0] sense, sense_prev, pend, ack;
  logic [NUM_PINS-1:0] arm, hide, lvl, any, inv;

  gpio_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(sense), .q_prev(sense_prev)
  );

  gpio_regs #(.W(NUM_PINS), .AW(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .sense(sense), .pend(pend),
    .drive(pin_out), .oe(pin_oe), .pull_on(pull_en), .pull_up(pull_up),
    .irq_arm(arm), .irq_hide(hide), .irq_lvl(lvl), .irq_any(any), .irq_inv(inv),
    .ack(ack)
  );

  gpio_irq_detect #(.W(NUM_PINS)) u_detect (
    .clk(clk), .rst(rst), .cur(sense), .prev(sense_prev),
    .arm(arm), .lvl(lvl), .inv(inv), .any(any), .hide(hide), .ack(ack),
    .pend(pend), .irq(irq)
  );
endmodule

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] pin_in = '0;
  logic [31:0] reg_rdata, pin_out, pin_oe, pull_en, pull_up;
  logic        irq;

  always #10 clk = ~clk;  // 50 MHz

  gpio_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pull_en(pull_en), .pull_up(pull_up),
    .irq(irq)
  );

  int    vecs = 0;
  int    errs = 0;
  int    cyc  = 0;
  string req  = "R1";

  // Behavioural reference state
  logic [31:0] m_drive, m_oe, m_pon, m_pup, m_arm, m_hide, m_lvl, m_any, m_inv;
  logic [31:0] m_fon, m_fdiv, m_pend, m_rdata;
  logic        m_irq;
  logic [31:0] pin_hist[$];

  function automatic logic [31:0] m_read(input logic [7:0] a, input logic [31:0] s);
    case (a)
      8'h00: return m_drive;
      8'h04: return s;
      8'h08: return m_oe;
      8'h18: return m_pon;
      8'h1C: return m_pup;
      8'h20: return m_arm;
      8'h24: return m_pend;
      8'h2C: return m_hide;
      8'h34: return m_lvl;
      8'h38: return m_any;
      8'h3C: return m_inv;
      8'h40: return m_fon;
      8'h44: return m_fdiv;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin : model
    logic [31:0] s, pv, ackv, nxt;
    bit ev;
    cyc++;
    if (rst) begin
      {m_drive, m_oe, m_pon, m_pup, m_arm, m_hide} = '0;
      {m_lvl, m_any, m_inv, m_fon, m_fdiv, m_pend, m_rdata} = '0;
      m_irq = 1'b0;
      pin_hist = '{32'h0, 32'h0, 32'h0};
    end else begin
      s    = pin_hist[1];
      pv   = pin_hist[2];
      ackv = (reg_wr && reg_addr == 8'h30) ? reg_wdata : 32'h0;
      m_irq = |(m_pend & ~m_hide);
      for (int i = 0; i < 32; i++) begin
        if (!m_arm[i]) nxt[i] = 1'b0;
        else if (m_lvl[i]) nxt[i] = m_inv[i] ? !s[i] : s[i];
        else begin
          if (m_any[i]) ev = (s[i] != pv[i]);
          else if (m_inv[i]) ev = pv[i] && !s[i];
          else ev = s[i] && !pv[i];
          nxt[i] = ev || (m_pend[i] && !ackv[i]);
        end
      end
      m_rdata = m_read(reg_addr, s);
      if (reg_wr) begin
        case (reg_addr)
          8'h00: m_drive = reg_wdata;
          8'h10: m_drive = m_drive | reg_wdata;
          8'h14: m_drive = m_drive & ~reg_wdata;
          8'h08: m_oe    = reg_wdata;
          8'h18: m_pon   = reg_wdata;
          8'h1C: m_pup   = reg_wdata;
          8'h20: m_arm   = reg_wdata;
          8'h2C: m_hide  = reg_wdata;
          8'h34: m_lvl   = reg_wdata;
          8'h38: m_any   = reg_wdata;
          8'h3C: m_inv   = reg_wdata;
          8'h40: m_fon   = reg_wdata;
          8'h44: m_fdiv  = reg_wdata;
          default: ;
        endcase
      end
      m_pend = nxt;
      pin_hist.push_front(pin_in);
      void'(pin_hist.pop_back());
    end
    if (cyc > 100000) begin
      errs++;
      $display("FAIL %s watchdog: cycles=%0d expected<=100000", req, cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (cyc > 0) begin
      bit bad;
      bad = 1'b0;
      vecs++;
      if (pin_out !== m_drive) begin bad = 1; $display("FAIL %s pin_out act=%h exp=%h", req, pin_out, m_drive); end
      if (pin_oe !== m_oe) begin bad = 1; $display("FAIL %s pin_oe act=%h exp=%h", req, pin_oe, m_oe); end
      if (pull_en !== m_pon) begin bad = 1; $display("FAIL %s pull_en act=%h exp=%h", req, pull_en, m_pon); end
      if (pull_up !== m_pup) begin bad = 1; $display("FAIL %s pull_up act=%h exp=%h", req, pull_up, m_pup); end
      if (irq !== m_irq) begin bad = 1; $display("FAIL %s irq act=%b exp=%b", req, irq, m_irq); end
      if (reg_rdata !== m_rdata) begin bad = 1; $display("FAIL %s reg_rdata act=%h exp=%h", req, reg_rdata, m_rdata); end
      if (bad) errs++;
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic pins(input logic [31:0] v);
    @(negedge clk);
    pin_in = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    idle(4);
    req = "R1";
    chk("R1 pin_out", pin_out, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rdata after release", reg_rdata, 32'h0);

    req = "R2";
    wr(8'h00, 32'hA5A5_0F0F);
    chk("R2 pin_out", pin_out, 32'hA5A5_0F0F);
    wr(8'h08, 32'hFFFF_0000);
    chk("R2 pin_oe", pin_oe, 32'hFFFF_0000);

    req = "R3";
    wr(8'h10, 32'h0000_00F0);
    wr(8'h14, 32'h0000_000F);
    chk("R3 set/clear", pin_out, 32'hA5A5_0FF0);

    req = "R4";
    pins(32'h1234_5678);
    idle(3);
    rd(8'h04, v);
    chk("R4 sense", v, 32'h1234_5678);
    rd(8'h00, v);
    chk("R4 drive readback", v, 32'hA5A5_0FF0);

    req = "R11";
    wr(8'h18, 32'h0F0F_0F0F);
    wr(8'h1C, 32'h00FF_00FF);
    chk("R11 pull_en", pull_en, 32'h0F0F_0F0F);
    chk("R11 pull_up", pull_up, 32'h00FF_00FF);
    wr(8'h44, 32'h0000_03E8);
    rd(8'h44, v);
    chk("R11 filter divider storage", v, 32'h0000_03E8);
    rd(8'h28, v);
    chk("R11 unmapped", v, 32'h0);
    rd(8'h10, v);
    chk("R11 set word reads zero", v, 32'h0);

    req = "R9";
    wr(8'h34, 32'hFFFF_FFFF);
    pins(32'hFFFF_FFFF);
    idle(4);
    rd(8'h24, v);
    chk("R9 unarmed status", v, 32'h0);
    chk("R9 irq", {31'h0, irq}, 32'h0);

    req = "R5";
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h3C, 32'h0000_FFFF);
    idle(3);
    rd(8'h24, v);
    chk("R5 level status", v, 32'hFFFF_0000);
    wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h24, v);
    chk("R5 ack ignored in level mode", v, 32'hFFFF_0000);

    req = "R6";
    wr(8'h34, 32'h0);
    wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h24, v);
    chk("R6 cleared", v, 32'h0);
    pins(32'h0);
    idle(4);
    rd(8'h24, v);
    chk("R6 falling latch", v, 32'h0000_FFFF);
    wr(8'h30, 32'hFFFF_FFFF);
    pins(32'hFFFF_FFFF);
    idle(4);
    rd(8'h24, v);
    chk("R6 rising latch", v, 32'hFFFF_0000);

    req = "R7";
    wr(8'h30, 32'hFFFF_FFFF);
    wr(8'h38, 32'h00F0_0000);
    pins(32'h0);
    idle(4);
    rd(8'h24, v);
    chk("R7 any-edge", v, 32'h00F0_FFFF);

    req = "R10";
    wr(8'h2C, 32'hFFFF_FFFF);
    idle(2);
    chk("R10 all hidden", {31'h0, irq}, 32'h0);
    rd(8'h24, v);
    chk("R10 hidden still latched", v, 32'h00F0_FFFF);
    wr(8'h2C, 32'hFF0F_FFFF);
    idle(2);
    chk("R10 unhidden raises irq", {31'h0, irq}, 32'h1);

    req = "R8";
    wr(8'h30, 32'hFFFF_FFFF);
    idle(2);
    pins(32'hFFFF_FFFF);
    idle(1);
    wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h24, v);
    chk("R8 edge beats ack", v, 32'hFFFF_0000);
    wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h24, v);
    chk("R8 later ack clears", v, 32'h0);

    idle(3);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule